// File: doc/BRIEF.md
# PCI Host Configuration Access Dispatcher

This block sits between a local processor port and the outbound side of a PCI host bridge. Software sees three 32-bit registers. The first is an address register with an enable bit. The second is a data window. The third is a read-only interrupt-acknowledge register. An access to the data window becomes a configuration cycle when the enable bit is set, and an I/O cycle when it is clear. A read of the interrupt-acknowledge register becomes an interrupt-acknowledge cycle.

Each bus cycle goes out on a simple downstream handshake. That handshake carries a command code, an address, active-high byte enables, write data, and the read data coming back. The byte strobes of the local access become the bus byte enables without any change. Byte 0 of the window is the least significant lane, because the configuration header is little-endian.

The local response is held back until the downstream port reports completion. Only one bus request can be outstanding at a time. Accesses that need no bus cycle are answered on the next cycle.

Top module: `pci_cfg_dispatch`

## Requirements
- R1: After reset, `loc_ack` and `bus_req` are low, `loc_rdata` is zero, and the address register reads back as zero.
- R2: A write to offset 0x0 updates the address register one byte per set strobe. Bits 1:0 always read back as zero. Bit 31 is the enable bit. The access is acknowledged one cycle after `loc_req`.
- R3: With the enable bit set, an access to offset 0x4 with at least one strobe drives `bus_req` one cycle after `loc_req`. It uses command code 1 (configuration), `bus_we` equal to `loc_we`, and `bus_addr` equal to the address register with bit 31 and bits 1:0 cleared.
- R4: With the enable bit clear, the same data-window access uses command code 2 (I/O) with the same address rule.
- R5: On a data-window access, `bus_be` equals `loc_be`, where bit 0 is lane bits 7:0 (little-endian), and `bus_wdata` equals `loc_wdata`.
- R6: A data-window read returns `bus_rdata` with every lane whose byte enable is clear forced to zero.
- R7: A data-window access with no strobe set issues no bus cycle. It is acknowledged one cycle after `loc_req` with zero data.
- R8: A read of offset 0x8 issues command code 3 (interrupt acknowledge) with `bus_be` all ones and `bus_we` low. It returns all 32 bits of `bus_rdata`.
- R9: A write to offset 0x8 issues no bus cycle and is acknowledged one cycle after `loc_req`.
- R10: While `bus_req` is high and `bus_done` is low, command, address, enables, direction and write data hold steady. `bus_req` falls and `loc_ack` pulses for exactly one cycle on the clock edge that sees `bus_done`.
- R11: A `loc_req` arriving while a bus request is outstanding is dropped. It starts no second bus cycle, produces no extra acknowledge, and writes no register.
- R12: An access to any other offset issues no bus cycle. It is acknowledged one cycle after `loc_req` with zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_req | input | 1 | One-cycle local access strobe |
| loc_we | input | 1 | Local access is a write |
| loc_off | input | OFF_W | Register byte offset |
| loc_be | input | DATA_W/8 | Local byte strobes, bit 0 = bits 7:0 |
| loc_wdata | input | DATA_W | Local write data |
| loc_ack | output | 1 | One-cycle completion pulse |
| loc_rdata | output | DATA_W | Read data, valid with `loc_ack` |
| bus_req | output | 1 | Downstream request, held until `bus_done` |
| bus_cmd | output | 2 | 1 configuration, 2 I/O, 3 interrupt acknowledge |
| bus_we | output | 1 | Downstream write |
| bus_addr | output | DATA_W | Downstream address |
| bus_be | output | DATA_W/8 | Active-high byte enables |
| bus_wdata | output | DATA_W | Downstream write data |
| bus_done | input | 1 | Downstream completion |
| bus_rdata | input | DATA_W | Downstream read data, valid with `bus_done` |

## Verification
A register-only access, meaning an address-register access, an ignored write, a strobeless access or an unmapped offset, must show `loc_ack` at the first falling edge after the strobe. A launching access must show `bus_req` with its fields at that same edge. The bench drives `bus_done` for one cycle after a chosen latency. It then expects `loc_ack` and a low `bus_req` at the very next falling edge, and checks at every cycle in between that the request fields stay unchanged. All sampling is done on falling edges, so each check lands exactly one register stage after the event that causes it.

// File: rtl/pci_cfgd_pkg.sv
package pci_cfgd_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_CFG  = 2'd1,
    CMD_IO   = 2'd2,
    CMD_IACK = 2'd3
  } bus_cmd_e;

  localparam int OFF_ADDR = 0;
  localparam int OFF_DATA = 4;
  localparam int OFF_IACK = 8;
endpackage

// File: rtl/cfgd_decode.sv
module cfgd_decode
  import pci_cfgd_pkg::*;
#(
  parameter int OFF_W = 4,
  parameter int BE_W  = 4
) (
  input  logic [OFF_W-1:0] off,
  input  logic             we,
  input  logic [BE_W-1:0]  be,
  input  logic             en,
  output logic             launch,
  output bus_cmd_e         cmd,
  output logic             hit_areg
);
  logic hit_data, hit_iack;

  always_comb begin
    hit_areg = (off == OFF_W'(OFF_ADDR));
    hit_data = (off == OFF_W'(OFF_DATA));
    hit_iack = (off == OFF_W'(OFF_IACK));
    launch   = (hit_data && (|be)) || (hit_iack && !we);
    if (!launch)      cmd = CMD_NONE;
    else if (hit_iack) cmd = CMD_IACK;
    else if (en)      cmd = CMD_CFG;
    else              cmd = CMD_IO;
  end
endmodule

// File: rtl/cfgd_lane_mask.sv
module cfgd_lane_mask #(
  parameter int BE_W = 4
) (
  input  logic [BE_W-1:0]   be,
  output logic [BE_W*8-1:0] mask
);
  for (genvar i = 0; i < BE_W; i++) begin : g_lane
    assign mask[i*8 +: 8] = {8{be[i]}};
  end
endmodule

// File: rtl/pci_cfg_dispatch.sv
module pci_cfg_dispatch
  import pci_cfgd_pkg::*;
#(
  parameter int OFF_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                loc_req,
  input  logic                loc_we,
  input  logic [OFF_W-1:0]    loc_off,
  input  logic [DATA_W/8-1:0] loc_be,
  input  logic [DATA_W-1:0]   loc_wdata,
  output logic                loc_ack,
  output logic [DATA_W-1:0]   loc_rdata,
  output logic                bus_req,
  output logic [1:0]          bus_cmd,
  output logic                bus_we,
  output logic [DATA_W-1:0]   bus_addr,
  output logic [DATA_W/8-1:0] bus_be,
  output logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_done,
  input  logic [DATA_W-1:0]   bus_rdata
);
  localparam int BE_W   = DATA_W / 8;
  localparam int EN_BIT = DATA_W - 1;

  typedef enum logic {ST_IDLE, ST_BUS} state_e;
  state_e state;

  logic [DATA_W-1:0] areg;
  logic              dec_launch;
  bus_cmd_e          dec_cmd;
  logic              dec_areg;
  logic [DATA_W-1:0] rd_mask;

  cfgd_decode #(.OFF_W(OFF_W), .BE_W(BE_W)) u_dec (
    .off      (loc_off),
    .we       (loc_we),
    .be       (loc_be),
    .en       (areg[EN_BIT]),
    .launch   (dec_launch),
    .cmd      (dec_cmd),
    .hit_areg (dec_areg)
  );

  cfgd_lane_mask #(.BE_W(BE_W)) u_mask (
    .be   (bus_be),
    .mask (rd_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      areg      <= '0;
      loc_ack   <= 1'b0;
      loc_rdata <= '0;
      bus_req   <= 1'b0;
      bus_cmd   <= CMD_NONE;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_be    <= '0;
      bus_wdata <= '0;
    end else begin
      loc_ack <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (loc_req) begin
            if (dec_launch) begin
              state     <= ST_BUS;
              bus_req   <= 1'b1;
              bus_cmd   <= dec_cmd;
              bus_we    <= loc_we;
              bus_addr  <= {1'b0, areg[DATA_W-2:2], 2'b00};
              bus_be    <= (dec_cmd == CMD_IACK) ? {BE_W{1'b1}} : loc_be;
              bus_wdata <= loc_wdata;
            end else begin
              loc_ack   <= 1'b1;
              loc_rdata <= (dec_areg && !loc_we) ? areg : '0;
              if (dec_areg && loc_we) begin
                for (int i = 0; i < BE_W; i++) begin
                  if (loc_be[i]) areg[i*8 +: 8] <= loc_wdata[i*8 +: 8];
                end
                areg[1:0] <= 2'b00;
              end
            end
          end
        end
        ST_BUS: begin
          if (bus_done) begin
            state     <= ST_IDLE;
            bus_req   <= 1'b0;
            loc_ack   <= 1'b1;
            loc_rdata <= bus_we ? '0 : (bus_rdata & rd_mask);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pci_cfgd_chk.sv
module pci_cfgd_chk #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                loc_ack,
  input logic                bus_req,
  input logic [1:0]          bus_cmd,
  input logic                bus_we,
  input logic [DATA_W-1:0]   bus_addr,
  input logic [DATA_W/8-1:0] bus_be,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic                bus_done
);
  assert_hold_fields_R10: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_done |=> bus_req && $stable(bus_cmd) && $stable(bus_addr)
      && $stable(bus_be) && $stable(bus_we) && $stable(bus_wdata));

  assert_done_release_R10: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_done |=> !bus_req && loc_ack);

  assert_ack_single_R10: assert property (@(posedge clk) disable iff (rst)
    loc_ack |=> !loc_ack);

  assert_no_ack_busy_R11: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> !loc_ack);

  assert_cmd_valid_R3: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> bus_cmd != 2'd0);

  assert_lanes_set_R7: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> bus_be != '0);

  assert_iack_shape_R8: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_cmd == 2'd3 |-> bus_be == '1 && !bus_we);

  assert_addr_low_R3: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> bus_addr[1:0] == 2'b00 && !bus_addr[DATA_W-1]);
endmodule

bind pci_cfg_dispatch pci_cfgd_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .loc_ack   (loc_ack),
  .bus_req   (bus_req),
  .bus_cmd   (bus_cmd),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .bus_done  (bus_done)
);

// File: tb/tb_pci_cfg_dispatch.sv
module tb_pci_cfg_dispatch;
  localparam int OFF_W = 4;
  localparam int DW    = 32;
  localparam int BW    = DW / 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          loc_req = 1'b0, loc_we = 1'b0;
  logic [OFF_W-1:0] loc_off = '0;
  logic [BW-1:0] loc_be = '0;
  logic [DW-1:0] loc_wdata = '0;
  logic          loc_ack;
  logic [DW-1:0] loc_rdata;
  logic          bus_req, bus_we;
  logic [1:0]    bus_cmd;
  logic [DW-1:0] bus_addr, bus_wdata;
  logic [BW-1:0] bus_be;
  logic          bus_done = 1'b0;
  logic [DW-1:0] bus_rdata = '0;

  always #10 clk = ~clk;

  pci_cfg_dispatch #(.OFF_W(OFF_W), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .loc_req(loc_req), .loc_we(loc_we), .loc_off(loc_off),
    .loc_be(loc_be), .loc_wdata(loc_wdata), .loc_ack(loc_ack), .loc_rdata(loc_rdata),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata)
  );

  int n_chk = 0, n_fail = 0;
  logic finished = 1'b0;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic          we;
    logic [3:0]    off;
    logic [3:0]    be;
    logic [31:0]   wdata;
    logic [31:0]   rsp;
    logic          exp_bus;
    logic [1:0]    exp_cmd;
    logic [31:0]   exp_addr;
    logic [31:0]   exp_rdata;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 4'h0, 4'hF, 32'h8000_1A07, 32'h0,         1'b0, 2'd0, 32'h0,         32'h0},
    '{1'b0, 4'h0, 4'hF, 32'h0,         32'h0,         1'b0, 2'd0, 32'h0,         32'h8000_1A04},
    '{1'b0, 4'h4, 4'hF, 32'h0,         32'hDEAD_BEEF, 1'b1, 2'd1, 32'h0000_1A04, 32'hDEAD_BEEF},
    '{1'b0, 4'h4, 4'h2, 32'h0,         32'h1122_3344, 1'b1, 2'd1, 32'h0000_1A04, 32'h0000_3300},
    '{1'b1, 4'h4, 4'hC, 32'hAABB_CCDD, 32'h0,         1'b1, 2'd1, 32'h0000_1A04, 32'h0},
    '{1'b0, 4'h8, 4'h1, 32'h0,         32'h0000_0042, 1'b1, 2'd3, 32'h0000_1A04, 32'h0000_0042},
    '{1'b1, 4'h8, 4'hF, 32'h1234_5678, 32'h0,         1'b0, 2'd0, 32'h0,         32'h0},
    '{1'b0, 4'hC, 4'hF, 32'h0,         32'h0,         1'b0, 2'd0, 32'h0,         32'h0},
    '{1'b1, 4'h0, 4'h8, 32'h0000_0000, 32'h0,         1'b0, 2'd0, 32'h0,         32'h0},
    '{1'b0, 4'h4, 4'h7, 32'h0,         32'hFFFF_FFFF, 1'b1, 2'd2, 32'h0000_1A04, 32'h00FF_FFFF},
    '{1'b0, 4'h4, 4'h0, 32'h0,         32'h5555_5555, 1'b0, 2'd0, 32'h0,         32'h0},
    '{1'b0, 4'h0, 4'hF, 32'h0,         32'h0,         1'b0, 2'd0, 32'h0,         32'h0000_1A04}
  };

  // One access: strobe at a falling edge, serve the bus with the given latency.
  task automatic access(input string req, input vec_t v, input int lat);
    logic [BW-1:0] exp_be;
    loc_req = 1'b1; loc_we = v.we; loc_off = v.off; loc_be = v.be; loc_wdata = v.wdata;
    @(negedge clk);
    loc_req = 1'b0;
    if (!v.exp_bus) begin
      check({req, " bus idle"}, {31'b0, bus_req}, 32'd0);
      check({req, " ack after one cycle"}, {31'b0, loc_ack}, 32'd1);
      check({req, " rdata"}, loc_rdata, v.exp_rdata);
    end else begin
      exp_be = (v.exp_cmd == 2'd3) ? 4'hF : v.be;
      check({req, " R3 req after one cycle"}, {31'b0, bus_req}, 32'd1);
      check({req, " cmd"}, {30'b0, bus_cmd}, {30'b0, v.exp_cmd});
      check({req, " addr"}, bus_addr, v.exp_addr);
      check({req, " R5 be"}, {28'b0, bus_be}, {28'b0, exp_be});
      check({req, " we"}, {31'b0, bus_we}, {31'b0, v.we});
      if (v.we) check({req, " R5 wdata"}, bus_wdata, v.wdata);
      for (int i = 0; i < lat; i++) begin
        check({req, " R10 held"}, {31'b0, bus_req & ~loc_ack}, 32'd1);
        @(negedge clk);
      end
      bus_done = 1'b1; bus_rdata = v.rsp;
      @(negedge clk);
      bus_done = 1'b0; bus_rdata = '0;
      check({req, " R10 ack after done"}, {31'b0, loc_ack}, 32'd1);
      check({req, " R10 req dropped"}, {31'b0, bus_req}, 32'd0);
      check({req, " R6 rdata"}, loc_rdata, v.exp_rdata);
    end
    @(negedge clk);
    check({req, " R10 ack single"}, {31'b0, loc_ack}, 32'd0);
  endtask

  initial begin
    int cycles = 0;
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ack", {31'b0, loc_ack}, 32'd0);
    check("R1 bus_req", {31'b0, bus_req}, 32'd0);
    check("R1 rdata", loc_rdata, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    v = '{1'b0, 4'h0, 4'hF, 32'h0, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0};
    access("R1 areg after reset", v, 0);

    // Vector table: R2 R3 R4 R5 R6 R7 R8 R9 R12
    for (int k = 0; k < NV; k++) access($sformatf("vec%0d R2-R12", k), TBL[k], 2);

    // R10: long latency with stable fields
    v = '{1'b1, 4'h0, 4'hF, 32'h8000_0F10, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0};
    access("R2 set enable", v, 0);
    v = '{1'b0, 4'h4, 4'h9, 32'h0, 32'hA1B2_C3D4, 1'b1, 2'd1, 32'h0000_0F10, 32'hA100_00D4};
    access("R10 long latency", v, 6);

    // R11: request while busy is dropped
    loc_req = 1'b1; loc_we = 1'b0; loc_off = 4'h4; loc_be = 4'hF; loc_wdata = '0;
    @(negedge clk);
    loc_we = 1'b1; loc_off = 4'h0; loc_be = 4'hF; loc_wdata = 32'h0000_0000;
    @(negedge clk);
    loc_req = 1'b0;
    check("R11 no ack while busy", {31'b0, loc_ack}, 32'd0);
    bus_done = 1'b1; bus_rdata = 32'h0BAD_F00D;
    @(negedge clk);
    bus_done = 1'b0;
    check("R11 first ack", {31'b0, loc_ack}, 32'd1);
    check("R11 first rdata", loc_rdata, 32'h0BAD_F00D);
    @(negedge clk);
    check("R11 no second ack", {31'b0, loc_ack}, 32'd0);
    check("R11 no second req", {31'b0, bus_req}, 32'd0);
    v = '{1'b0, 4'h0, 4'hF, 32'h0, 32'h0, 1'b0, 2'd0, 32'h0, 32'h8000_0F10};
    access("R11 areg untouched", v, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule